// File: doc/BRIEF.md
# ADC Conversion Sequencer with Automatic Sleep

This block is the digital controller for a multi-channel successive-approximation ADC. The analog cell has a comparator and a trial DAC, and it sits outside the block. All logic runs on the main clock. A programmable divider makes a slower conversion clock and a matching one-cycle enable, and every sequencing step advances on that enable.

A trigger starts a scan. The block converts every enabled channel once, in ascending index order. When sleep mode is on, the analog cell is held powered down between scans. A trigger raises the power, and the block waits a programmable start-up time before the first sample. Each conversion has a sample phase of programmable length, followed by a bit-by-bit search driven by the comparator input. Each result goes into a per-channel slot and into a last-result register, with a one-cycle ready pulse.

Results are 10 bits by default. A low-resolution control selects 8-bit results, and a per-channel override keeps selected channels at 10 bits whatever the low-resolution setting.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `adc_clk` has a period of exactly 2*(`cfg_prescale`+1) main clock cycles.
- R2: After reset, `busy`, `drdy` and all `eoc` bits are 0, and `last_data` and every `ch_data` slot are 0.
- R3: With `cfg_lowres`=0, each result equals the largest 10-bit code C for which the comparator reports input >= C. The comparator `cmp_ge` is 1 when the analog input is at or above `dac_code`, and `dac_code` is always on the 10-bit scale.
- R4: With `cfg_lowres`=1 and no override on the channel, the result is the 10-bit value shifted right by two. Bits [9:8] of the stored result are 0.
- R5: A channel whose bit in `cfg_force_hr` is 1 gives a 10-bit result even when `cfg_lowres`=1.
- R6: `xfer_16` is 1 when the latest result was 10-bit and 0 when it was 8-bit, so it gives the width of the transfer word (16 or 8 bits).
- R7: One scan converts exactly the enabled channels (`cfg_ch_en`) in ascending index order. The slots of disabled channels keep their values.
- R8: With `cfg_sleep_en`=1, `pwr_down` is 1 while idle and 0 for the whole scan. It returns to 1 in the same cycle that `busy` falls.
- R9: With sleep on, the first `sample_en` rises exactly (`cfg_startup`+1)*T cycles after `pwr_down` falls, where T is the `adc_clk` period.
- R10: Each sample phase (`sample_en` high) lasts (`cfg_sh_cycles`+1)*T cycles.
- R11: With `cfg_sleep_en`=0, `pwr_down` stays 0 and sampling starts within 2*T cycles of the trigger, with no start-up wait.
- R12: A trigger that arrives while a scan is in progress is ignored: no extra result, and no new scan afterwards.
- R13: At the start of a scan all `eoc` bits clear. Each result sets its channel's `eoc` bit and raises `drdy` for exactly one cycle, with `last_ch` and `last_data` valid in that cycle.
- R14: A trigger with no channel enabled starts no scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale | input | PRE_W | Divider setting; conversion clock period is 2*(value+1) |
| cfg_lowres | input | 1 | 1 selects 8-bit results |
| cfg_force_hr | input | NCH | Per-channel override that keeps 10-bit results |
| cfg_ch_en | input | NCH | Channel enable mask |
| cfg_sleep_en | input | 1 | Power the cell down between scans |
| cfg_startup | input | SU_W | Start-up wait, in conversion clocks minus one |
| cfg_sh_cycles | input | SH_W | Sample length, in conversion clocks minus one |
| trig | input | 1 | Scan request |
| cmp_ge | input | 1 | Comparator: analog input >= dac_code |
| adc_clk | output | 1 | Divided conversion clock |
| pwr_down | output | 1 | Analog cell power-down |
| busy | output | 1 | Scan in progress |
| sample_en | output | 1 | Sample-and-hold phase active |
| ch_sel | output | CW | Channel being converted |
| dac_code | output | RES_W | Trial code for the comparator (10-bit scale) |
| ch_data | output | NCH*RES_W | Per-channel results, channel i at bits [i*RES_W +: RES_W] |
| last_data | output | RES_W | Most recent result |
| last_ch | output | CW | Channel of the most recent result |
| eoc | output | NCH | Per-channel end-of-conversion flags |
| drdy | output | 1 | One-cycle pulse when last_data updates |
| xfer_16 | output | 1 | Width of the latest result: 1 = 16-bit word, 0 = 8-bit |

## Verification
A bad search-bit pointer or a lost comparator decision shows up as a wrong `last_data` at the very next `drdy` pulse, within one conversion. A sequencer that skips or repeats a channel shows as an unexpected `last_ch`, or as the wrong number of `drdy` pulses before `busy` falls. A faulty start-up or sample counter moves the edges of `sample_en` by whole conversion-clock periods, and the bench measures those edges to the cycle. A fault in the power-control path shows as `pwr_down` disagreeing with `busy` in the cycle the scan starts or ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Sequencer phases. Every transition except leaving ST_CONV is
  // taken on a conversion-clock enable.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SAMPLE,
    ST_CONV,
    ST_NEXT
  } seq_state_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] div,
  output logic             adc_clk,
  output logic             tick
);

  logic [PRE_W-1:0] half_cnt;
  logic             ck_q;
  logic             wrap;

  // Compare with >= so that a smaller setting written mid-count still wraps.
  assign wrap = (half_cnt >= div);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt <= '0;
      ck_q     <= 1'b0;
    end else if (wrap) begin
      half_cnt <= '0;
      ck_q     <= ~ck_q;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  // One enable per full period, in the cycle before the falling edge.
  assign tick    = wrap & ck_q;
  assign adc_clk = ck_q;

endmodule

// File: rtl/adc_sar_loop.sv
module adc_sar_loop #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             start_hr,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] trial,
  output logic             done,
  output logic [RES_W-1:0] res,
  output logic             res_hr
);

  localparam int BW = $clog2(RES_W);

  logic [RES_W-1:0] code;
  logic [BW-1:0]    bitp;
  logic             act;
  logic             hr;
  logic [RES_W-1:0] probe;
  logic [BW-1:0]    lsb_pos;

  assign probe   = code | (RES_W'(1) << bitp);
  assign lsb_pos = hr ? '0 : BW'(RES_W - LO_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      bitp <= '0;
      act  <= 1'b0;
      hr   <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        code <= '0;
        bitp <= BW'(RES_W - 1);
        act  <= 1'b1;
        hr   <= start_hr;
      end else if (act && tick) begin
        if (cmp_ge) code <= probe;
        if (bitp == lsb_pos) begin
          act  <= 1'b0;
          done <= 1'b1;
        end else begin
          bitp <= bitp - 1'b1;
        end
      end
    end
  end

  assign trial  = act ? probe : '0;
  assign res    = code;
  assign res_hr = hr;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH   = 4,
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  localparam int CW   = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 we,
  input  logic [CW-1:0]        wch,
  input  logic [RES_W-1:0]     wcode,
  input  logic                 whr,
  output logic [NCH*RES_W-1:0] ch_data,
  output logic [RES_W-1:0]     last_data,
  output logic [CW-1:0]        last_ch,
  output logic [NCH-1:0]       eoc,
  output logic                 drdy,
  output logic                 xfer_16
);

  logic [RES_W-1:0] slot [NCH];
  logic [RES_W-1:0] fmt;

  // A low-resolution code keeps only its upper bits, moved down to the LSBs.
  assign fmt = whr ? wcode : (wcode >> (RES_W - LO_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) slot[i] <= '0;
      last_data <= '0;
      last_ch   <= '0;
      eoc       <= '0;
      drdy      <= 1'b0;
      xfer_16   <= 1'b1;
    end else begin
      drdy <= we;
      if (clr) eoc <= '0;
      if (we) begin
        slot[wch]    <= fmt;
        last_data    <= fmt;
        last_ch      <= wch;
        eoc[wch]     <= 1'b1;
        xfer_16      <= whr;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_data[g*RES_W +: RES_W] = slot[g];
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH   = 4,
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  parameter int PRE_W = 6,
  parameter int SH_W  = 4,
  parameter int SU_W  = 8,
  localparam int CW   = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PRE_W-1:0]     cfg_prescale,
  input  logic                 cfg_lowres,
  input  logic [NCH-1:0]       cfg_force_hr,
  input  logic [NCH-1:0]       cfg_ch_en,
  input  logic                 cfg_sleep_en,
  input  logic [SU_W-1:0]      cfg_startup,
  input  logic [SH_W-1:0]      cfg_sh_cycles,
  input  logic                 trig,
  input  logic                 cmp_ge,
  output logic                 adc_clk,
  output logic                 pwr_down,
  output logic                 busy,
  output logic                 sample_en,
  output logic [CW-1:0]        ch_sel,
  output logic [RES_W-1:0]     dac_code,
  output logic [NCH*RES_W-1:0] ch_data,
  output logic [RES_W-1:0]     last_data,
  output logic [CW-1:0]        last_ch,
  output logic [NCH-1:0]       eoc,
  output logic                 drdy,
  output logic                 xfer_16
);

  import adc_seq_pkg::*;

  seq_state_t       st, st_n;
  logic             tick;
  logic             pend;
  logic [CW-1:0]    ch, ch_n;
  logic [SU_W-1:0]  wk_cnt;
  logic [SH_W-1:0]  sh_cnt;
  logic             accept, sar_start, sar_done, sar_hr;
  logic [RES_W-1:0] sar_res;
  logic             first_any, rem_any;
  logic [CW-1:0]    first_idx, rem_idx;
  logic [NCH-1:0]   rem_mask;

  adc_clk_div #(.PRE_W(PRE_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .div     (cfg_prescale),
    .adc_clk (adc_clk),
    .tick    (tick)
  );

  // Lowest enabled channel overall, and lowest enabled channel above ch.
  always_comb begin
    rem_mask  = cfg_ch_en & ~((NCH'(2) << ch) - NCH'(1));
    first_any = |cfg_ch_en;
    rem_any   = |rem_mask;
    first_idx = '0;
    rem_idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cfg_ch_en[i]) first_idx = CW'(i);
      if (rem_mask[i])  rem_idx   = CW'(i);
    end
  end

  always_comb begin
    st_n      = st;
    ch_n      = ch;
    accept    = 1'b0;
    sar_start = 1'b0;
    case (st)
      ST_IDLE: begin
        if (tick && pend && first_any) begin
          accept = 1'b1;
          ch_n   = first_idx;
          st_n   = cfg_sleep_en ? ST_WAKE : ST_SAMPLE;
        end
      end
      ST_WAKE: begin
        if (tick && wk_cnt == cfg_startup) st_n = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (tick && sh_cnt == cfg_sh_cycles) begin
          st_n      = ST_CONV;
          sar_start = 1'b1;
        end
      end
      ST_CONV: begin
        if (sar_done) st_n = ST_NEXT;
      end
      ST_NEXT: begin
        if (tick) begin
          if (rem_any) begin
            ch_n = rem_idx;
            st_n = ST_SAMPLE;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ch       <= '0;
      pend     <= 1'b0;
      wk_cnt   <= '0;
      sh_cnt   <= '0;
      pwr_down <= 1'b1;
    end else begin
      st <= st_n;
      ch <= ch_n;
      if (accept)
        pend <= 1'b0;
      else if (st == ST_IDLE && tick && !first_any)
        pend <= 1'b0;
      else if (trig && st == ST_IDLE)
        pend <= 1'b1;
      wk_cnt   <= (st == ST_WAKE)   ? (tick ? wk_cnt + 1'b1 : wk_cnt) : '0;
      sh_cnt   <= (st == ST_SAMPLE) ? (tick ? sh_cnt + 1'b1 : sh_cnt) : '0;
      pwr_down <= cfg_sleep_en && (st_n == ST_IDLE);
    end
  end

  adc_sar_loop #(.RES_W(RES_W), .LO_W(LO_W)) u_sar (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .start    (sar_start),
    .start_hr (!cfg_lowres || cfg_force_hr[ch]),
    .cmp_ge   (cmp_ge),
    .trial    (dac_code),
    .done     (sar_done),
    .res      (sar_res),
    .res_hr   (sar_hr)
  );

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W), .LO_W(LO_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept),
    .we        (sar_done),
    .wch       (ch),
    .wcode     (sar_res),
    .whr       (sar_hr),
    .ch_data   (ch_data),
    .last_data (last_data),
    .last_ch   (last_ch),
    .eoc       (eoc),
    .drdy      (drdy),
    .xfer_16   (xfer_16)
  );

  assign busy      = (st != ST_IDLE);
  assign sample_en = (st == ST_SAMPLE);
  assign ch_sel    = ch;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int NCH   = 4,
  parameter int RES_W = 10,
  localparam int CW   = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_sleep_en,
  input logic             pwr_down,
  input logic             busy,
  input logic             sample_en,
  input logic             drdy,
  input logic [NCH-1:0]   eoc,
  input logic [CW-1:0]    last_ch,
  input logic [RES_W-1:0] last_data,
  input logic             xfer_16
);

  AST_DRDY_PULSE: assert property (@(posedge clk) disable iff (rst) drdy |=> !drdy); // R13
  AST_EOC_WITH_DRDY: assert property (@(posedge clk) disable iff (rst) drdy |-> eoc[last_ch]); // R13
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst) !xfer_16 |-> last_data[RES_W-1 -: 2] == 2'b00); // R4
  AST_PWR_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst) pwr_down |-> !busy); // R8
  AST_NO_SLEEP_POWERED: assert property (@(posedge clk) disable iff (rst) !cfg_sleep_en |=> !pwr_down); // R11
  AST_SAMPLE_POWERED: assert property (@(posedge clk) disable iff (rst) sample_en |-> (busy && !pwr_down)); // R9

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH), .RES_W(RES_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_sleep_en (cfg_sleep_en),
  .pwr_down     (pwr_down),
  .busy         (busy),
  .sample_en    (sample_en),
  .drdy         (drdy),
  .eoc          (eoc),
  .last_ch      (last_ch),
  .last_data    (last_data),
  .xfer_16      (xfer_16)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int NCH = 4;
  localparam int W   = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst;
  logic [5:0]     cfg_prescale;
  logic           cfg_lowres;
  logic [NCH-1:0] cfg_force_hr;
  logic [NCH-1:0] cfg_ch_en;
  logic           cfg_sleep_en;
  logic [7:0]     cfg_startup;
  logic [3:0]     cfg_sh_cycles;
  logic           trig;
  logic           cmp_ge;
  logic           adc_clk, pwr_down, busy, sample_en, drdy, xfer_16;
  logic [1:0]     ch_sel, last_ch;
  logic [W-1:0]   dac_code, last_data;
  logic [NCH*W-1:0] ch_data;
  logic [NCH-1:0] eoc;

  logic [W-1:0] ain [NCH];
  assign cmp_ge = (ain[ch_sel] >= dac_code);

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_prescale(cfg_prescale), .cfg_lowres(cfg_lowres),
    .cfg_force_hr(cfg_force_hr), .cfg_ch_en(cfg_ch_en), .cfg_sleep_en(cfg_sleep_en),
    .cfg_startup(cfg_startup), .cfg_sh_cycles(cfg_sh_cycles), .trig(trig), .cmp_ge(cmp_ge),
    .adc_clk(adc_clk), .pwr_down(pwr_down), .busy(busy), .sample_en(sample_en),
    .ch_sel(ch_sel), .dac_code(dac_code), .ch_data(ch_data), .last_data(last_data),
    .last_ch(last_ch), .eoc(eoc), .drdy(drdy), .xfer_16(xfer_16)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_mem [NCH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_val(input int a, input bit hr);
    return hr ? a : (a >> 2);
  endfunction

  function automatic int popc(input logic [NCH-1:0] m);
    int n = 0;
    for (int i = 0; i < NCH; i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic int next_en(input logic [NCH-1:0] m, input int above);
    for (int i = above + 1; i < NCH; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // R1: conversion clock period
  task automatic measure_period();
    int t0, t1;
    int tp = 2 * (int'(cfg_prescale) + 1);
    @(posedge adc_clk); @(negedge clk); t0 = cyc;
    @(posedge adc_clk); @(negedge clk); t1 = cyc;
    chk((t1 - t0) == tp, "R1 adc_clk period", t1 - t0, tp);
  endtask

  task automatic run_scan(input bit extra_trig);
    int tp = 2 * (int'(cfg_prescale) + 1);
    int t_trig, t_busy, t_samp, slen, nres, idx, n, exv;
    bit seen_s, s_done, pd_bad, hr, got_busy;
    logic [NCH-1:0] exp_eoc;
    @(negedge clk); trig = 1'b1; t_trig = cyc;
    @(negedge clk); trig = 1'b0;
    if (cfg_ch_en == '0) begin
      got_busy = 0;
      repeat (4 * tp + 4) begin @(negedge clk); if (busy || drdy) got_busy = 1; end
      chk(!got_busy, "R14 no scan without enabled channel", got_busy, 0);
      return;
    end
    got_busy = busy;
    for (int k = 0; k < 4 * tp + 10 && !got_busy; k++) begin
      @(negedge clk); got_busy = busy;
    end
    t_busy = cyc;
    chk(got_busy, "R7 scan starts", got_busy, 1);
    exp_eoc = '0; idx = next_en(cfg_ch_en, -1);
    seen_s = 0; s_done = 0; slen = 0; nres = 0; pd_bad = 0; n = 0; t_samp = 0;
    while (busy && n < 20000) begin
      if (sample_en && !seen_s) begin seen_s = 1; t_samp = cyc; end
      if (seen_s && !s_done) begin if (sample_en) slen++; else s_done = 1; end
      if (pwr_down) pd_bad = 1;
      if (drdy) begin
        hr  = !cfg_lowres || cfg_force_hr[idx];
        exv = exp_val(int'(ain[idx]), hr);
        chk(int'(last_ch) == idx, "R7 channel order", int'(last_ch), idx);
        chk(int'(last_data) == exv, hr ? (cfg_lowres ? "R5 forced 10-bit" : "R3 10-bit result")
                                       : "R4 8-bit result", int'(last_data), exv);
        chk(xfer_16 == hr, "R6 transfer width", xfer_16, hr);
        exp_mem[idx] = exv;
        exp_eoc[idx] = 1'b1;
        chk(eoc == exp_eoc, "R13 eoc flags", int'(eoc), int'(exp_eoc));
        nres++;
        idx = next_en(cfg_ch_en, idx);
      end
      @(negedge clk);
      trig = extra_trig && (n == 5);
      n++;
    end
    trig = 1'b0;
    chk(!pd_bad, cfg_sleep_en ? "R8 powered during scan" : "R11 never powered down", pd_bad, 0);
    chk(nres == popc(cfg_ch_en), "R12 one result per enabled channel", nres, popc(cfg_ch_en));
    if (cfg_sleep_en) begin
      chk(pwr_down == 1'b1, "R8 power down at scan end", pwr_down, 1);
      chk((t_samp - t_busy) == (int'(cfg_startup) + 1) * tp, "R9 start-up wait",
          t_samp - t_busy, (int'(cfg_startup) + 1) * tp);
    end else begin
      chk((t_samp - t_trig) <= 2 * tp, "R11 no start-up wait", t_samp - t_trig, 2 * tp);
    end
    chk(slen == (int'(cfg_sh_cycles) + 1) * tp, "R10 sample length", slen,
        (int'(cfg_sh_cycles) + 1) * tp);
    got_busy = 0;
    repeat (3 * tp + 4) begin @(negedge clk); if (busy || drdy) got_busy = 1; end
    chk(!got_busy, "R12 trigger during scan ignored", got_busy, 0);
    for (int c = 0; c < NCH; c++)
      chk(int'(ch_data[c*W +: W]) == exp_mem[c], "R7 channel slots", int'(ch_data[c*W +: W]), exp_mem[c]);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0A0C);
    rst = 1'b1; trig = 1'b0;
    cfg_prescale = 6'd1; cfg_lowres = 1'b0; cfg_force_hr = '0; cfg_ch_en = 4'b1111;
    cfg_sleep_en = 1'b1; cfg_startup = 8'd3; cfg_sh_cycles = 4'd2;
    ain[0] = 10'd0; ain[1] = 10'd1023; ain[2] = 10'd512; ain[3] = 10'd513;
    for (int c = 0; c < NCH; c++) exp_mem[c] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R2: reset state
    chk(!busy && !drdy && eoc == '0 && last_data == '0 && ch_data == '0, "R2 reset state",
        int'(busy) + int'(drdy) + int'(eoc) + int'(last_data), 0);
    repeat (3) @(negedge clk);
    chk(pwr_down == 1'b1, "R8 idle powered down", pwr_down, 1);
    measure_period();
    run_scan(1'b0);                          // 10-bit, extremes, sleep
    cfg_lowres = 1'b1; cfg_force_hr = 4'b0010; cfg_ch_en = 4'b1011;
    ain[0] = 10'd3; ain[1] = 10'd777; ain[2] = 10'd100; ain[3] = 10'd1022;
    run_scan(1'b1);                          // 8-bit, override, skip ch2
    cfg_sleep_en = 1'b0; cfg_prescale = 6'd0; cfg_sh_cycles = 4'd0; cfg_lowres = 1'b0;
    repeat (4) @(negedge clk);
    measure_period();
    run_scan(1'b1);                          // no sleep
    cfg_ch_en = '0;
    run_scan(1'b0);                          // R14
    for (int r = 0; r < 12; r++) begin
      cfg_prescale  = 6'($urandom_range(0, 3));
      cfg_lowres    = 1'($urandom_range(0, 1));
      cfg_force_hr  = NCH'($urandom_range(0, 15));
      cfg_ch_en     = NCH'($urandom_range(1, 15));
      cfg_sleep_en  = 1'($urandom_range(0, 1));
      cfg_startup   = 8'($urandom_range(0, 5));
      cfg_sh_cycles = 4'($urandom_range(0, 3));
      for (int c = 0; c < NCH; c++) ain[c] = W'($urandom_range(0, 1023));
      repeat (6) @(negedge clk);
      if (r % 4 == 0) measure_period();
      run_scan(1'($urandom_range(0, 1)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule